// File: doc/BRIEF.md
# Shared-Medium Transmit Access Controller

This block decides when a station on a shared half-duplex link may put a frame on the wire. A client pulses a send request together with a payload length in bytes. The controller waits while another station holds the carrier, and it keeps a quiet gap after the medium goes idle. It then raises transmit enable for the whole frame. A payload shorter than the minimum frame is padded, and a payload longer than the maximum is clipped. The line coder downstream serialises the bits whenever transmit enable is high.

If a collision is reported while the frame is going out, the controller stops the data and sends a fixed-length jam. A collision inside the first minimum-frame's worth of bits counts as a normal collision. The controller then waits a random number of slot times, drawn from a truncated binary exponential window, and retries. A collision later in the frame is reported and not retried. Too many failed attempts abort the frame with its own status.

All time is kept in bit times counted on a bit-tick strobe, and backoff is measured in slots of `SLOT_BITS` bit times. The defaults are a 512-bit slot, 64-byte minimum, 1518-byte maximum, 96-bit quiet gap, 32-bit jam, a backoff exponent capped at 10 and 16 attempts.

Top module: `csma_tx_mac`

## Requirements
- R1: During and right after reset, txEn, jamOn, padOn, txDone, txAbortLate and txAbortExcess are all low.
- R2: If the medium has been idle for at least IFG_BITS bit ticks when frameReq is seen, txEn is high on the very next clock.
- R3: txEn never rises in the clock after a cycle in which carrierSense was high. Once carrierSense drops, txEn rises only after IFG_BITS idle bit ticks (IFG_BITS+1 clocks with one tick per clock).
- R4: A request issued in the cycle of txDone waits the same IFG_BITS idle bit ticks, counted from the end of the station's own transmission.
- R5: With the length L clipped to MAX_BYTES, a collision-free frame keeps txEn high for max(L, MIN_BYTES)*8 bit ticks. txDone is high for one clock in the cycle after the last one.
- R6: padOn is high during the trailing bits beyond L*8, which is max(L,MIN_BYTES)*8 - L*8 ticks, and is low otherwise.
- R7: A collision at bit index below MIN_BYTES*8 moves to jam on the next clock. txEn and jamOn then stay high for JAM_BITS ticks, after which the frame is retried.
- R8: After the n-th collision, txEn stays low for max(r*SLOT_BITS+2, IFG_BITS+1) clocks, with r an integer in [0, 2^min(n,BACKOFF_LIMIT)-1] drawn from a free-running LFSR. Successive draws differ.
- R9: A collision at bit index MIN_BYTES*8 or later is jammed for JAM_BITS ticks and then reported by a one-clock txAbortLate. There is no retry and no txDone.
- R10: When the ATTEMPT_LIMIT-th consecutive collision of a frame has been jammed, a one-clock txAbortExcess is given and no further attempt is made.
- R11: A collision on the final bit of a frame takes precedence over completion. It is retried if that bit index is below MIN_BYTES*8 and is reported late otherwise.
- R12: At most one of txDone, txAbortLate and txAbortExcess is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One pulse per bit time |
| frameReq | input | 1 | Single-clock send request, taken when idle |
| frameLen | input | LEN_W | Payload length in bytes, captured with frameReq |
| carrierSense | input | 1 | Medium busy indication |
| collisionDetect | input | 1 | Collision indication from the line |
| txEn | output | 1 | Transmit enable, high for data, pad and jam |
| jamOn | output | 1 | Jam pattern is being sent |
| padOn | output | 1 | Pad bits are being sent |
| txDone | output | 1 | Frame sent without collision |
| txAbortLate | output | 1 | Frame dropped after a late collision |
| txAbortExcess | output | 1 | Frame dropped after too many collisions |

## Verification
Two events can land on the same clock: the last bit of a frame and a collision report. The bench provokes this by raising collisionDetect exactly when the final bit is on the line. It does this once for a minimum-length frame, where the collision must lead to jam and a retry, and once for a full-length frame, where it must give a late abort and no txDone. The case where the quiet gap and the backoff expire together is also covered. Every gap between attempts is judged against the set of values allowed by the slot size and the current backoff window.

// File: rtl/csma_tx_pkg.sv
package csma_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_SEND,
    ST_JAM,
    ST_BACKOFF
  } macState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startFrame;   // capture length, clear attempt count
    logic clrBits;      // restart the bit counter
    logic stepBits;     // advance the bit counter
    logic loadBackoff;  // draw a fresh backoff
    logic stepBackoff;  // advance the backoff timer
    logic bumpAttempt;  // one more collision for this frame
    logic inSend;       // data or pad on the wire
    logic onAir;        // own transmitter active
  } ctrlStrobe_t;

  // Conditions reported back by the datapath
  typedef struct packed {
    logic idleOk;
    logic lastBit;
    logic pastSlot;
    logic jamLast;
    logic backoffZero;
    logic finalAttempt;
  } dpFlags_t;

endpackage

// File: rtl/csma_tx_dp.sv
module csma_tx_dp
  import csma_tx_pkg::*;
#(
  parameter int SLOT_BITS     = 512,
  parameter int MIN_BYTES     = 64,
  parameter int MAX_BYTES     = 1518,
  parameter int IFG_BITS      = 96,
  parameter int JAM_BITS      = 32,
  parameter int BACKOFF_LIMIT = 10,
  parameter int ATTEMPT_LIMIT = 16,
  parameter int LEN_W         = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             carrierSense,
  input  logic [LEN_W-1:0] frameLen,
  input  ctrlStrobe_t      strb,
  output dpFlags_t         flg,
  output logic             padOn
);

  localparam int MIN_BITS = MIN_BYTES * 8;
  localparam int MAX_BITS = MAX_BYTES * 8;
  localparam int BIT_W    = $clog2(MAX_BITS + 1);
  localparam int IDLE_W   = $clog2(IFG_BITS + 1);
  localparam int SLOT_W   = $clog2(SLOT_BITS);
  localparam int ATT_W    = $clog2(ATTEMPT_LIMIT + 1);
  localparam int LFSR_W   = 16;

  logic [BIT_W-1:0]         lenBits, lenLoad, frameBits, bitCnt;
  logic [IDLE_W-1:0]        idleCnt;
  logic [ATT_W-1:0]         attempts, nextAttempts;
  logic [LFSR_W-1:0]        lfsr;
  logic [BACKOFF_LIMIT-1:0] backoffMask, slotsLeft;
  logic [SLOT_W-1:0]        slotBit;
  int                       expoSel;

  // Length capture with clipping to the maximum frame
  always_comb begin
    if (int'(frameLen) > MAX_BYTES) lenLoad = BIT_W'(MAX_BITS);
    else                            lenLoad = BIT_W'(int'(frameLen) * 8);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                lenBits <= '0;
    else if (strb.startFrame) lenBits <= lenLoad;
  end

  assign frameBits = (lenBits < BIT_W'(MIN_BITS)) ? BIT_W'(MIN_BITS) : lenBits;

  // Shared bit counter: frame bits in SEND, jam bits in JAM
  always_ff @(posedge clk) begin
    if (!rstN)              bitCnt <= '0;
    else if (strb.clrBits)  bitCnt <= '0;
    else if (strb.stepBits) bitCnt <= bitCnt + BIT_W'(1);
  end

  assign flg.lastBit  = (bitCnt == frameBits - BIT_W'(1));
  assign flg.pastSlot = (bitCnt >= BIT_W'(MIN_BITS));
  assign flg.jamLast  = (bitCnt == BIT_W'(JAM_BITS - 1));
  assign padOn        = strb.inSend && (bitCnt >= lenBits);

  // Quiet-gap counter, cleared while anyone is on the medium
  always_ff @(posedge clk) begin
    if (!rstN)                                   idleCnt <= '0;
    else if (strb.onAir || carrierSense)         idleCnt <= '0;
    else if (bitTick && idleCnt != IDLE_W'(IFG_BITS)) idleCnt <= idleCnt + IDLE_W'(1);
  end

  assign flg.idleOk = (idleCnt == IDLE_W'(IFG_BITS));

  // Collision count for the current frame
  always_ff @(posedge clk) begin
    if (!rstN)                 attempts <= '0;
    else if (strb.startFrame)  attempts <= '0;
    else if (strb.bumpAttempt) attempts <= nextAttempts;
  end

  assign nextAttempts     = attempts + ATT_W'(1);
  assign flg.finalAttempt = (attempts == ATT_W'(ATTEMPT_LIMIT - 1));

  // Free-running maximal-length LFSR
  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= 16'hACE1;
    else       lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // Truncated exponential window mask
  assign expoSel = (int'(nextAttempts) < BACKOFF_LIMIT) ? int'(nextAttempts) : BACKOFF_LIMIT;

  for (genvar g = 0; g < BACKOFF_LIMIT; g++) begin : g_mask
    assign backoffMask[g] = (g < expoSel);
  end

  // Backoff timer: slots remaining and bit position within a slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotsLeft <= '0;
      slotBit   <= '0;
    end else if (strb.loadBackoff) begin
      slotsLeft <= lfsr[BACKOFF_LIMIT-1:0] & backoffMask;
      slotBit   <= '0;
    end else if (strb.stepBackoff) begin
      if (slotBit == SLOT_W'(SLOT_BITS - 1)) begin
        slotBit   <= '0;
        slotsLeft <= slotsLeft - BACKOFF_LIMIT'(1);
      end else begin
        slotBit <= slotBit + SLOT_W'(1);
      end
    end
  end

  assign flg.backoffZero = (slotsLeft == '0);

  assert_attempt_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    attempts <= ATT_W'(ATTEMPT_LIMIT - 1));

  assert_frame_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.inSend |-> bitCnt < BIT_W'(MAX_BITS));

  assert_backoff_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepBackoff |-> !strb.onAir);

endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
  import csma_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        frameReq,
  input  logic        carrierSense,
  input  logic        collisionDetect,
  input  dpFlags_t    flg,
  output ctrlStrobe_t strb,
  output logic        txEn,
  output logic        jamOn,
  output logic        txDone,
  output logic        txAbortLate,
  output logic        txAbortExcess
);

  macState_t state, nextState;
  logic lateFlag, lateSet;
  logic doneNext, lateNext, excessNext;

  always_comb begin
    nextState   = state;
    strb        = '0;
    strb.inSend = (state == ST_SEND);
    strb.onAir  = (state == ST_SEND) || (state == ST_JAM);
    lateSet     = lateFlag;
    doneNext    = 1'b0;
    lateNext    = 1'b0;
    excessNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (frameReq) begin
          strb.startFrame = 1'b1;
          strb.clrBits    = 1'b1;
          lateSet         = 1'b0;
          nextState = (flg.idleOk && !carrierSense) ? ST_SEND : ST_DEFER;
        end
      end
      ST_DEFER: begin
        if (flg.idleOk && !carrierSense) begin
          strb.clrBits = 1'b1;
          nextState    = ST_SEND;
        end
      end
      ST_SEND: begin
        if (collisionDetect) begin
          strb.clrBits = 1'b1;
          lateSet      = flg.pastSlot;
          nextState    = ST_JAM;
        end else if (bitTick) begin
          if (flg.lastBit) begin
            doneNext  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.stepBits = 1'b1;
          end
        end
      end
      ST_JAM: begin
        if (bitTick) begin
          if (flg.jamLast) begin
            if (lateFlag) begin
              lateNext  = 1'b1;
              nextState = ST_IDLE;
            end else if (flg.finalAttempt) begin
              excessNext = 1'b1;
              nextState  = ST_IDLE;
            end else begin
              strb.bumpAttempt = 1'b1;
              strb.loadBackoff = 1'b1;
              nextState        = ST_BACKOFF;
            end
          end else begin
            strb.stepBits = 1'b1;
          end
        end
      end
      ST_BACKOFF: begin
        if (flg.backoffZero)  nextState = ST_DEFER;
        else if (bitTick)     strb.stepBackoff = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      lateFlag      <= 1'b0;
      txDone        <= 1'b0;
      txAbortLate   <= 1'b0;
      txAbortExcess <= 1'b0;
    end else begin
      state         <= nextState;
      lateFlag      <= lateSet;
      txDone        <= doneNext;
      txAbortLate   <= lateNext;
      txAbortExcess <= excessNext;
    end
  end

  assign txEn  = (state == ST_SEND) || (state == ST_JAM);
  assign jamOn = (state == ST_JAM);

  assert_defer_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> !$past(carrierSense));

  assert_jam_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !jamOn && collisionDetect) |=> jamOn);

  assert_one_status_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txDone, txAbortLate, txAbortExcess}));

  assert_done_clean_R5: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (!txEn && $past(txEn) && !$past(jamOn)));

  assert_late_after_jam_R9: assert property (@(posedge clk) disable iff (!rstN)
    txAbortLate |-> $past(jamOn));

endmodule

// File: rtl/csma_tx_mac.sv
module csma_tx_mac
  import csma_tx_pkg::*;
#(
  parameter int SLOT_BITS     = 512,
  parameter int MIN_BYTES     = 64,
  parameter int MAX_BYTES     = 1518,
  parameter int IFG_BITS      = 96,
  parameter int JAM_BITS      = 32,
  parameter int BACKOFF_LIMIT = 10,
  parameter int ATTEMPT_LIMIT = 16,
  parameter int LEN_W         = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             frameReq,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             carrierSense,
  input  logic             collisionDetect,
  output logic             txEn,
  output logic             jamOn,
  output logic             padOn,
  output logic             txDone,
  output logic             txAbortLate,
  output logic             txAbortExcess
);

  ctrlStrobe_t strb;
  dpFlags_t    flg;

  csma_tx_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .bitTick        (bitTick),
    .frameReq       (frameReq),
    .carrierSense   (carrierSense),
    .collisionDetect(collisionDetect),
    .flg            (flg),
    .strb           (strb),
    .txEn           (txEn),
    .jamOn          (jamOn),
    .txDone         (txDone),
    .txAbortLate    (txAbortLate),
    .txAbortExcess  (txAbortExcess)
  );

  csma_tx_dp #(
    .SLOT_BITS    (SLOT_BITS),
    .MIN_BYTES    (MIN_BYTES),
    .MAX_BYTES    (MAX_BYTES),
    .IFG_BITS     (IFG_BITS),
    .JAM_BITS     (JAM_BITS),
    .BACKOFF_LIMIT(BACKOFF_LIMIT),
    .ATTEMPT_LIMIT(ATTEMPT_LIMIT),
    .LEN_W        (LEN_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .bitTick     (bitTick),
    .carrierSense(carrierSense),
    .frameLen    (frameLen),
    .strb        (strb),
    .flg         (flg),
    .padOn       (padOn)
  );

endmodule

// File: tb/csma_tx_mac_bench.sv
module csma_tx_mac_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SLOT  = 16;
  localparam int MINB  = 4;
  localparam int MAXB  = 12;
  localparam int IFG   = 12;
  localparam int JAM   = 8;
  localparam int BLIM  = 4;
  localparam int ALIM  = 16;
  localparam int LENW  = 6;

  logic clk = 1'b0;
  logic rstN, bitTick, frameReq, carrierSense, collisionDetect;
  logic [LENW-1:0] frameLen;
  logic txEn, jamOn, padOn, txDone, txAbortLate, txAbortExcess;

  int checks = 0;
  int fails  = 0;

  int oBursts, oFirst, oLast, oPad, oJam, oDone, oLate, oExcess, oGapBad, oMulti;
  int gapMin, gapMax;

  always #(CLK_PERIOD/2) clk = ~clk;

  csma_tx_mac #(
    .SLOT_BITS(SLOT), .MIN_BYTES(MINB), .MAX_BYTES(MAXB), .IFG_BITS(IFG),
    .JAM_BITS(JAM), .BACKOFF_LIMIT(BLIM), .ATTEMPT_LIMIT(ALIM), .LEN_W(LENW)
  ) u_csma_tx_mac (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .frameReq(frameReq),
    .frameLen(frameLen), .carrierSense(carrierSense),
    .collisionDetect(collisionDetect), .txEn(txEn), .jamOn(jamOn),
    .padOn(padOn), .txDone(txDone), .txAbortLate(txAbortLate),
    .txAbortExcess(txAbortExcess)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clipLen(input int len);
    return (len > MAXB) ? MAXB : len;
  endfunction

  function automatic int frameBits(input int len);
    return ((clipLen(len) < MINB) ? MINB : clipLen(len)) * 8;
  endfunction

  function automatic int padBits(input int len);
    return frameBits(len) - clipLen(len) * 8;
  endfunction

  function automatic bit gapLegal(input int gap, input int n);
    int e = (n < BLIM) ? n : BLIM;
    if (gap == IFG + 1) return 1'b1;
    if (gap < IFG + 1) return 1'b0;
    if ((gap - 2) % SLOT != 0) return 1'b0;
    return ((gap - 2) / SLOT) <= ((1 << e) - 1);
  endfunction

  task automatic kick(input int len);
    frameReq = 1'b1;
    frameLen = LENW'(len);
    @(negedge clk);
    frameReq = 1'b0;
  endtask

  // Watches one frame from the current negedge until a status pulse
  task automatic observe(input int collAt, input bit holdColl);
    int  cur = 0;
    int  gap = 0;
    bit  prev = 1'b0;
    bit  fin = 1'b0;
    oBursts = 0; oFirst = 0; oLast = 0; oPad = 0; oJam = 0;
    oDone = 0; oLate = 0; oExcess = 0; oGapBad = 0; oMulti = 0;
    gapMin = 1 << 30; gapMax = 0;
    for (int c = 0; c < 20000 && !fin; c++) begin
      if (txEn) begin
        if (!prev) begin
          if (oBursts > 0) begin
            if (!gapLegal(gap, oBursts)) oGapBad++;
            if (gap < gapMin) gapMin = gap;
            if (gap > gapMax) gapMax = gap;
          end
          oBursts++;
          cur = 0;
          gap = 0;
          oPad = 0;
        end
        cur++;
        if (oBursts == 1) oFirst = cur;
        oLast = cur;
        if (padOn) oPad++;
        if (jamOn) oJam++;
        collisionDetect = holdColl || (oBursts == 1 && !jamOn && (cur - 1) == collAt);
      end else begin
        collisionDetect = holdColl;
        if (oBursts > 0) gap++;
      end
      prev = txEn;
      if ((32'(txDone) + 32'(txAbortLate) + 32'(txAbortExcess)) > 1) oMulti++;
      if (txDone) oDone++;
      if (txAbortLate) oLate++;
      if (txAbortExcess) oExcess++;
      if (txDone || txAbortLate || txAbortExcess) fin = 1'b1;
      else @(negedge clk);
    end
    collisionDetect = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int lowSeen;
    int len, mode, collAt, fb;
    rstN = 1'b0; bitTick = 1'b1; frameReq = 1'b0; frameLen = '0;
    carrierSense = 1'b0; collisionDetect = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkEq("R1 outputs low in reset",
      32'({txEn, jamOn, padOn, txDone, txAbortLate, txAbortExcess}), 0);
    rstN = 1'b1;
    repeat (IFG + 4) @(negedge clk);
    checkEq("R1 outputs low after reset",
      32'({txEn, jamOn, padOn, txDone, txAbortLate, txAbortExcess}), 0);

    // R2: immediate start on an idle medium, plain frame with padding
    kick(2);
    checkEq("R2 txEn next clock", 32'(txEn), 1);
    observe(-1, 1'b0);
    checkEq("R5 frame bits short", oLast, frameBits(2));
    checkEq("R6 pad bits short", oPad, padBits(2));
    checkEq("R5 done pulse", oDone, 1);

    // R4: request in the done cycle waits the gap
    kick(MAXB);
    n = 1;
    while (!txEn && n < 1000) begin @(negedge clk); n++; end
    checkEq("R4 gap after own frame", n, IFG + 1);
    observe(-1, 1'b0);
    checkEq("R5 frame bits max", oLast, frameBits(MAXB));
    checkEq("R6 no pad at max", oPad, 0);

    // R3: defer while carrier is up
    repeat (IFG + 4) @(negedge clk);
    carrierSense = 1'b1;
    kick(6);
    lowSeen = 0;
    for (int i = 0; i < 25; i++) begin
      if (txEn) lowSeen++;
      @(negedge clk);
    end
    checkEq("R3 no start while busy", lowSeen, 0);
    carrierSense = 1'b0;
    n = 0;
    while (!txEn && n < 1000) begin @(negedge clk); n++; end
    checkEq("R3 start after carrier drop", n, IFG + 1);
    observe(-1, 1'b0);
    checkEq("R5 frame after defer", oLast, frameBits(6));

    // R5: clipping of an oversize length
    repeat (IFG + 4) @(negedge clk);
    kick(MAXB + 5);
    observe(-1, 1'b0);
    checkEq("R5 oversize clipped", oLast, MAXB * 8);

    // R11: collision on last bit of a minimum frame is retried
    repeat (IFG + 4) @(negedge clk);
    kick(MINB);
    observe(MINB * 8 - 1, 1'b0);
    checkEq("R11 min frame retried", oBursts, 2);
    checkEq("R11 min frame done", oDone, 1);
    checkEq("R7 jam length", oFirst, MINB * 8 + JAM);

    // R11: collision on last bit of a long frame is late
    repeat (IFG + 4) @(negedge clk);
    kick(MAXB);
    observe(MAXB * 8 - 1, 1'b0);
    checkEq("R11 long frame late", oLate, 1);
    checkEq("R11 long frame no done", oDone, 0);
    checkEq("R9 late jam length", oFirst, MAXB * 8 + JAM);

    // R10: collision on every attempt
    repeat (IFG + 4) @(negedge clk);
    kick(MINB);
    observe(-1, 1'b1);
    checkEq("R10 attempts", oBursts, ALIM);
    checkEq("R10 excess abort", oExcess, 1);
    checkEq("R10 no done", oDone, 0);
    checkEq("R7 jam per attempt", oJam, ALIM * JAM);
    checkEq("R8 legal backoff gaps", oGapBad, 0);
    checkEq("R8 gaps vary", 32'(gapMax > gapMin), 1);
    checkEq("R12 single status", oMulti, 0);

    // Constrained random frames
    for (int k = 0; k < 40; k++) begin
      repeat (IFG + 2 + $urandom_range(0, 5)) @(negedge clk);
      len  = $urandom_range(0, MAXB + 3);
      mode = $urandom_range(0, 2);
      fb   = frameBits(len);
      collAt = -1;
      if (mode == 1) collAt = $urandom_range(0, MINB * 8 - 1);
      if (mode == 2 && fb > MINB * 8) collAt = $urandom_range(MINB * 8, fb - 1);
      else if (mode == 2) mode = 0;
      kick(len);
      checkEq("R2 random start", 32'(txEn), 1);
      observe(collAt, 1'b0);
      checkEq("R12 random status", oMulti, 0);
      if (mode == 0) begin
        checkEq("R5 random frame", oLast, fb);
        checkEq("R6 random pad", oPad, padBits(len));
        checkEq("R5 random done", oDone, 1);
      end else if (mode == 1) begin
        checkEq("R7 random retry", oBursts, 2);
        checkEq("R7 random jam", oFirst, collAt + 1 + JAM);
        checkEq("R7 random retry frame", oLast, fb);
        checkEq("R6 random retry pad", oPad, padBits(len));
        checkEq("R8 random gap", oGapBad, 0);
      end else begin
        checkEq("R9 random late", oLate, 1);
        checkEq("R9 random no retry", oBursts, 1);
        checkEq("R9 random jam", oFirst, collAt + 1 + JAM);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule